// File: doc/BRIEF.md
# Floating-Point Write Tracking User Mask

This block holds a small user-visible mask register. Two of its bits are mode controls that software sets: one enables the user performance monitors, and one makes alignment checking strict. Two more bits are sticky status flags. Hardware sets them when a completing instruction writes a floating-point register in the low range or in the high range of the register file.

Each cycle the block can receive an instruction-completion event. The event carries a valid flag, a fault flag and a 7-bit floating-point target index. Software can overwrite the whole mask with a write-enable and a data word. The current mask value is presented on a read port in every cycle, and the two mode bits are also driven out as separate lines.

Top module: `fp_umask`

## Requirements
- R1: A synchronous active-low reset clears every bit of `rd_data` to 0, and it reads 0 in the cycle after the reset edge.
- R2: When `wr_en` is 1, bits 2, 3, 4 and 5 of `wr_data` appear on `rd_data` after the next rising edge. Bits 0, 1, 6 and 7 always read 0, and writes to them have no effect.
- R3: A completion with `cmp_valid`=1, `cmp_fault`=0 and `cmp_idx` from 2 to 31 sets bit 4 (low-range modified) after the next edge.
- R4: A completion with `cmp_valid`=1, `cmp_fault`=0 and `cmp_idx` from 32 to 127 sets bit 5 (high-range modified) after the next edge.
- R5: A completion whose target is index 0 or 1 changes neither bit 4 nor bit 5.
- R6: A completion with `cmp_valid`=0 or with `cmp_fault`=1 leaves the whole mask unchanged.
- R7: Bits 4 and 5 are sticky. Without a write, hardware never clears them, and a completion never changes bits 2 and 3.
- R8: When a write and a qualifying completion fall in the same cycle, the result is the written value with the completion's status bit ORed in.
- R9: `upm_en` always equals bit 2 of the mask and `align_strict` always equals bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Explicit mask write strobe |
| wr_data | input | REG_W (8) | Value to write into the mask |
| cmp_valid | input | 1 | A completion event is present |
| cmp_fault | input | 1 | The completing instruction faulted or was squashed |
| cmp_idx | input | FP_IDX_W (7) | Floating-point target register index |
| rd_data | output | REG_W (8) | Current mask value |
| upm_en | output | 1 | User performance monitor enable (bit 2) |
| align_strict | output | 1 | Strict alignment check (bit 3) |

## Verification
A software write and a qualifying completion can land in the same cycle. The two disagree about bits 4 and 5: the write may try to clear a flag that the completion sets. Random stimulus creates this collision often, and directed cases write all-zero while a low-range or a high-range completion fires. The result must equal the written bits ORed with the completion's flag, so a modification is never lost.

// File: rtl/fp_umask.sv
module fp_umask #(
  parameter int REG_W    = 8,
  parameter int FP_IDX_W = 7,
  parameter int LO_FIRST = 2,
  parameter int HI_FIRST = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic                cmp_valid,
  input  logic                cmp_fault,
  input  logic [FP_IDX_W-1:0] cmp_idx,
  output logic [REG_W-1:0]    rd_data,
  output logic                upm_en,
  output logic                align_strict
);
  localparam int UP_BIT = 2;
  localparam int AC_BIT = 3;
  localparam int LO_BIT = 4;
  localparam int HI_BIT = 5;
  localparam logic [REG_W-1:0] KEEP =
    REG_W'((1 << UP_BIT) | (1 << AC_BIT) | (1 << LO_BIT) | (1 << HI_BIT));

  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] base, set_bits;
  logic             hit, lo_hit, hi_hit;

  assign hit    = cmp_valid && !cmp_fault;
  assign lo_hit = hit && (cmp_idx >= FP_IDX_W'(LO_FIRST)) && (cmp_idx < FP_IDX_W'(HI_FIRST));
  assign hi_hit = hit && (cmp_idx >= FP_IDX_W'(HI_FIRST));

  assign base     = (wr_en ? wr_data : mask_q) & KEEP;
  assign set_bits = (REG_W'(lo_hit) << LO_BIT) | (REG_W'(hi_hit) << HI_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= base | set_bits;
  end

  assign rd_data      = mask_q;
  assign upm_en       = mask_q[UP_BIT];
  assign align_strict = mask_q[AC_BIT];
endmodule

// File: rtl/fp_umask_chk.sv
module fp_umask_chk #(
  parameter int REG_W    = 8,
  parameter int FP_IDX_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic                cmp_valid,
  input logic                cmp_fault,
  input logic [FP_IDX_W-1:0] cmp_idx,
  input logic [REG_W-1:0]    rd_data,
  input logic                upm_en,
  input logic                align_strict
);
  logic ok_evt, lo_evt, hi_evt;
  assign ok_evt = cmp_valid && !cmp_fault;
  assign lo_evt = ok_evt && cmp_idx >= FP_IDX_W'(2) && cmp_idx < FP_IDX_W'(32);
  assign hi_evt = ok_evt && cmp_idx >= FP_IDX_W'(32);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> rd_data == '0);
  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[3:2] == $past(wr_data[3:2]) && rd_data[1:0] == 2'b00);
  // R3
  lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n) lo_evt |=> rd_data[4]);
  // R4
  hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n) hi_evt |=> rd_data[5]);
  // R5
  low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cmp_idx < FP_IDX_W'(2)) |=> $stable(rd_data[5:4]));
  // R6
  no_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ok_evt) |=> $stable(rd_data));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data[5:4] & $past(rd_data[5:4])) == $past(rd_data[5:4]) && $stable(rd_data[3:2]));
  // R8
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (lo_evt || hi_evt)) |=> rd_data[5:4] == ($past(wr_data[5:4]) | {$past(hi_evt), $past(lo_evt)}));
  // R9
  mode_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upm_en == rd_data[2] && align_strict == rd_data[3]);
endmodule

bind fp_umask fp_umask_chk #(.REG_W(REG_W), .FP_IDX_W(FP_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .cmp_valid(cmp_valid), .cmp_fault(cmp_fault), .cmp_idx(cmp_idx),
  .rd_data(rd_data), .upm_en(upm_en), .align_strict(align_strict)
);

// File: tb/tb_fp_umask.sv
`timescale 1ns/1ps
module tb_fp_umask;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       cmp_valid = 0;
  logic       cmp_fault = 0;
  logic [6:0] cmp_idx = '0;
  logic [7:0] rd_data;
  logic       upm_en, align_strict;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model = '0;

  always #4 clk = ~clk;

  fp_umask dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmp_valid(cmp_valid), .cmp_fault(cmp_fault), .cmp_idx(cmp_idx),
    .rd_data(rd_data), .upm_en(upm_en), .align_strict(align_strict)
  );

  function automatic logic [7:0] next_mask(logic [7:0] cur, logic w, logic [7:0] wd,
                                           logic v, logic f, logic [6:0] ix);
    logic [7:0] r;
    r = (w ? wd : cur) & 8'h3C;
    if (v && !f && ix >= 2 && ix <= 31) r[4] = 1'b1;
    if (v && !f && ix >= 32) r[5] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(logic w, logic v, logic f, logic [6:0] ix);
    if (w && v && !f && ix >= 2) return "R8";
    if (w) return "R2";
    if (!v || f) return "R6";
    if (ix < 2) return "R5";
    if (ix <= 31) return "R3";
    return "R4";
  endfunction

  task automatic compare(string tag, logic [7:0] exp);
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s rd_data=%h expected=%h", tag, rd_data, exp);
    end
    n_cmp++;
    if (upm_en !== exp[2] || align_strict !== exp[3]) begin
      n_bad++;
      $display("FAIL R9 modes=%b%b expected=%b%b", align_strict, upm_en, exp[3], exp[2]);
    end
  endtask

  task automatic step(logic w, logic [7:0] wd, logic v, logic f, logic [6:0] ix, string tag = "");
    logic [7:0] exp;
    wr_en = w; wr_data = wd; cmp_valid = v; cmp_fault = f; cmp_idx = ix;
    exp = next_mask(model, w, wd, v, f, ix);
    @(negedge clk);
    compare(tag == "" ? tag_of(w, v, f, ix) : tag, exp);
    model = exp;
    wr_en = 0; cmp_valid = 0; cmp_fault = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; cmp_valid = 0;
    @(negedge clk);
    @(negedge clk);
    model = '0;
    compare("R1", 8'h00);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [6:0] edges [6];
    void'($urandom(32'h5EED_0042));
    edges = '{7'd0, 7'd1, 7'd2, 7'd31, 7'd32, 7'd127};
    do_reset();

    // R2: reserved bits ignore writes
    step(1, 8'hFF, 0, 0, 0);
    step(1, 8'hC3, 0, 0, 0);
    // R5: fixed registers
    step(0, 0, 1, 0, 7'd0);
    step(0, 0, 1, 0, 7'd1);
    // R3 / R4 boundaries
    step(0, 0, 1, 0, 7'd2);
    step(1, 8'h00, 0, 0, 0);
    step(0, 0, 1, 0, 7'd31);
    step(0, 0, 1, 0, 7'd32);
    step(1, 8'h0C, 0, 0, 0);
    step(0, 0, 1, 0, 7'd127);
    // R6: faulted and invalid
    step(0, 0, 1, 1, 7'd10);
    step(0, 0, 0, 0, 7'd50);
    // R7: stickiness across idle cycles and the other range
    step(0, 0, 1, 0, 7'd5);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 7'd3, "R7");
    step(0, 0, 1, 0, 7'd40, "R7");
    // R8: write of zero collides with sets
    step(1, 8'h00, 1, 0, 7'd2);
    step(1, 8'h00, 1, 0, 7'd99);
    step(1, 8'h04, 1, 1, 7'd20);
    // R1: reset mid-run
    step(1, 8'h3C, 0, 0, 0);
    do_reset();

    for (int i = 0; i < 3000; i++) begin
      logic w, v, f;
      logic [7:0] wd;
      logic [6:0] ix;
      w  = ($urandom_range(0, 7) == 0);
      wd = 8'($urandom);
      v  = $urandom_range(0, 1) == 1;
      f  = ($urandom_range(0, 7) == 0);
      ix = ($urandom_range(0, 3) == 0) ? edges[$urandom_range(0, 5)] : 7'($urandom);
      step(w, wd, v, f, ix);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule